// File: doc/BRIEF.md
# Integer-to-Float Normalize Unit

This block carries out the normalize instruction of a processor. The instruction converts a signed 16-bit integer from an accumulator into a normalized floating point value. It writes the result into a group of three 16-bit registers that together form the floating point accumulator. The low byte of the instruction word is a signed scaling constant, and this constant sets the exponent. With a scaling of +16 the float equals the integer. Each extra step of scaling doubles the result.

The result layout is fixed:

- The upper word (T) holds the sign in bit 15 and a biased exponent in bits 14:0.
- The middle word (A) holds the mantissa. It is left-justified so that bit 15 is set.
- The low word (D) is always cleared, because the source has only one word of precision.

The value represented is (A/2^16) * 2^(exponent - bias).

A format-select input chooses 48-bit mode, where all three words are written, or 32-bit mode, where the T word is left as it was. The operation takes a fixed two cycles from the start strobe. The unit holds the three register words and drives one write-enable pulse per word, in step with a single-cycle done pulse.

Top module: `nlz_norm_unit`

## Requirements
- R1: The operation is recognised only when `start` is high and instruction bits 15:8 equal 0xD3 (octal 151400 with the low byte clear). Any other instruction produces no done pulse and no write enable, and leaves all three register words unchanged.
- R2: For an accepted start in cycle c, `done` is high in cycle c+2 only. It is low in cycle c+1 and again in cycle c+3.
- R3: `aWe` and `dWe` are high exactly in the done cycle. `tWe` is high in the done cycle only when `fmt48` was 1 at start.
- R4: In 32-bit mode (`fmt48`=0 at start), the T word keeps its previous value and `tWe` stays low. A and D are still written.
- R5: The D word is 0x0000 after every completed operation.
- R6: For a nonzero operand, A equals the operand's magnitude shifted left by its number of leading zeros, so A bit 15 is 1.
- R7: T bit 15 is the sign of the operand (1 = negative). T bits 14:0 equal (scaling - leading zeros + EXP_BIAS) modulo 2^15, where scaling is instruction bits 7:0 read as a signed value and EXP_BIAS defaults to 16384.
- R8: With instruction 0xD310 (scaling +16), the float value equals the integer. For example, operand 1 gives T=0x4001, A=0x8000, D=0.
- R9: Raising the scaling by one raises the exponent field by one and leaves the mantissa unchanged, so the value doubles.
- R10: Operand -32768 is handled as magnitude 0x8000. With scaling +16 this gives T=0xC010 and A=0x8000.
- R11: A zero operand gives T, A and D all zero in 48-bit mode, whatever the scaling.
- R12: The full signed scaling range works. Scaling -128 (low byte 0x80) and +127 (0x7F) give exponent fields 16384-128-lz and 16384+127-lz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| instr | input | 16 | Instruction word; bits 15:8 opcode, bits 7:0 signed scaling |
| operand | input | 16 | Signed integer to convert |
| fmt48 | input | 1 | 1 = 48-bit format (write T), 0 = 32-bit format |
| tReg | output | 16 | Sign and biased exponent word |
| aReg | output | 16 | Normalized mantissa word |
| dReg | output | 16 | Low mantissa word (always cleared) |
| tWe | output | 1 | Write enable for T, done cycle only |
| aWe | output | 1 | Write enable for A, done cycle only |
| dWe | output | 1 | Write enable for D, done cycle only |
| done | output | 1 | One-cycle completion pulse |

## Verification
A fault in the captured sign, magnitude or scale appears in the register words in the very cycle `done` rises, two cycles after start. In that cycle it shows as:

- a mantissa without bit 15 set;
- a sign bit that disagrees with the operand;
- an exponent off by the leading-zero count.

A stuck or extra valid bit in the control shows instead as a missing, doubled or late done pulse, or as a T write enable in 32-bit mode. Either way it is visible one cycle after the expected point. A fault in the T-hold path shows only on a later 32-bit operation, as a changed T word.

// File: rtl/nlz_pkg.sv
package nlz_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SCALE_W = 8;
  localparam logic [7:0] OPCODE_HI = 8'hD3;

  typedef struct packed {
    logic loadOp;
    logic commitAD;
    logic commitT;
  } nlzStrobe_t;
endpackage

// File: rtl/nlz_lzc.sv
module nlz_lzc #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value,
  output logic [CNT_W-1:0] zeroCount
);
  always_comb begin
    zeroCount = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (value[i]) begin
        zeroCount = CNT_W'(WIDTH - 1 - i);
      end
    end
  end
endmodule

// File: rtl/nlz_ctrl.sv
module nlz_ctrl
  import nlz_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opHigh,
  input  logic       fmt48,
  output nlzStrobe_t strobes,
  output logic       tWe,
  output logic       aWe,
  output logic       dWe,
  output logic       done
);
  logic accept;
  logic stageValid;
  logic stageFmt48;

  assign accept = start && (opHigh == OPCODE_HI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageFmt48 <= 1'b0;
    end else begin
      stageValid <= accept;
      if (accept) stageFmt48 <= fmt48;
    end
  end

  always_comb begin
    strobes.loadOp   = accept;
    strobes.commitAD = stageValid;
    strobes.commitT  = stageValid && stageFmt48;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0;
      tWe  <= 1'b0;
      aWe  <= 1'b0;
      dWe  <= 1'b0;
    end else begin
      done <= stageValid;
      aWe  <= stageValid;
      dWe  <= stageValid;
      tWe  <= stageValid && stageFmt48;
    end
  end
endmodule

// File: rtl/nlz_datapath.sv
module nlz_datapath
  import nlz_pkg::*;
#(
  parameter int unsigned EXP_BIAS = 16384,
  localparam int unsigned EXP_W = WORD_W - 1,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  nlzStrobe_t         strobes,
  input  logic [WORD_W-1:0]  operand,
  input  logic [SCALE_W-1:0] scale,
  output logic [WORD_W-1:0]  tReg,
  output logic [WORD_W-1:0]  aReg,
  output logic [WORD_W-1:0]  dReg
);
  logic               negQ;
  logic [WORD_W-1:0]  magQ;
  logic [SCALE_W-1:0] scaleQ;
  logic [WORD_W-1:0]  magIn;
  logic [CNT_W-1:0]   lzCount;
  logic [WORD_W-1:0]  mantissa;
  logic [EXP_W-1:0]   scaleExt;
  logic [EXP_W-1:0]   expField;
  logic               isZero;

  // two's complement to sign-magnitude; -32768 maps to 0x8000 unsigned
  assign magIn = operand[WORD_W-1] ? (~operand + 1'b1) : operand;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      negQ   <= 1'b0;
      magQ   <= '0;
      scaleQ <= '0;
    end else if (strobes.loadOp) begin
      negQ   <= operand[WORD_W-1];
      magQ   <= magIn;
      scaleQ <= scale;
    end
  end

  nlz_lzc #(.WIDTH(WORD_W)) u_lzc (
    .value(magQ),
    .zeroCount(lzCount)
  );

  assign isZero   = (magQ == '0);
  assign mantissa = magQ << lzCount;
  assign scaleExt = {{(EXP_W-SCALE_W){scaleQ[SCALE_W-1]}}, scaleQ};
  assign expField = scaleExt - EXP_W'(lzCount) + EXP_W'(EXP_BIAS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tReg <= '0;
      aReg <= '0;
      dReg <= '0;
    end else begin
      if (strobes.commitAD) begin
        aReg <= isZero ? '0 : mantissa;
        dReg <= '0;
      end
      if (strobes.commitT) begin
        tReg <= isZero ? '0 : {negQ, expField};
      end
    end
  end
endmodule

// File: rtl/nlz_norm_unit.sv
module nlz_norm_unit
  import nlz_pkg::*;
#(
  parameter int unsigned EXP_BIAS = 16384
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] instr,
  input  logic [15:0] operand,
  input  logic        fmt48,
  output logic [15:0] tReg,
  output logic [15:0] aReg,
  output logic [15:0] dReg,
  output logic        tWe,
  output logic        aWe,
  output logic        dWe,
  output logic        done
);
  nlzStrobe_t strobes;

  nlz_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .start(start),
    .opHigh(instr[15:8]),
    .fmt48(fmt48),
    .strobes(strobes),
    .tWe(tWe),
    .aWe(aWe),
    .dWe(dWe),
    .done(done)
  );

  nlz_datapath #(.EXP_BIAS(EXP_BIAS)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .operand(operand),
    .scale(instr[7:0]),
    .tReg(tReg),
    .aReg(aReg),
    .dReg(dReg)
  );
endmodule

// File: rtl/nlz_norm_checker.sv
module nlz_norm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [15:0] instr,
  input logic        fmt48,
  input logic [15:0] tReg,
  input logic [15:0] aReg,
  input logic [15:0] dReg,
  input logic        tWe,
  input logic        aWe,
  input logic        dWe,
  input logic        done
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(start, 2) && $past(instr[15:8], 2) == 8'hD3));

  assert_we_with_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tWe || aWe || dWe) |-> done);

  assert_t_fmt_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (tWe == $past(fmt48, 2)));

  assert_t_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !tWe) |-> $stable(tReg));

  assert_d_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (dReg == 16'h0000));

  assert_mant_norm_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && aReg != 16'h0000) |-> aReg[15]);

  assert_zero_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && tWe && aReg == 16'h0000) |-> (tReg == 16'h0000));
endmodule

bind nlz_norm_unit nlz_norm_checker u_chk (
  .clk(clk),
  .rstN(rstN),
  .start(start),
  .instr(instr),
  .fmt48(fmt48),
  .tReg(tReg),
  .aReg(aReg),
  .dReg(dReg),
  .tWe(tWe),
  .aWe(aWe),
  .dWe(dWe),
  .done(done)
);

// File: tb/sim_nlz_norm_unit.sv
module sim_nlz_norm_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [15:0] operand = 16'h0000;
  logic        fmt48 = 1'b1;
  logic [15:0] tReg, aReg, dReg;
  logic        tWe, aWe, dWe, done;

  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  nlz_norm_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .operand(operand),
    .fmt48(fmt48), .tReg(tReg), .aReg(aReg), .dReg(dReg),
    .tWe(tWe), .aWe(aWe), .dWe(dWe), .done(done)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {T,A} from the requirements
  function automatic logic [31:0] model(input logic [15:0] ins, input logic [15:0] op);
    logic [15:0] mag;
    int lz;
    int e;
    mag = op[15] ? (~op + 16'd1) : op;
    if (mag == 16'd0) return 32'd0;
    lz = 0;
    for (int i = 15; i >= 0; i--) begin
      if (mag[i]) break;
      lz++;
    end
    e = int'($signed(ins[7:0])) - lz + 16384;
    return {op[15], e[14:0], mag << lz};
  endfunction

  // issue one op; check timing, enables and results
  task automatic runOp(input string req, input logic [15:0] ins, input logic [15:0] op,
                       input logic f48);
    logic [15:0] tBefore;
    logic [31:0] expv;
    tBefore = tReg;
    expv = model(ins, op);
    instr = ins; operand = op; fmt48 = f48; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0; operand = 16'h5A5A; fmt48 = ~f48;
    check({req, " R2 done low c+1"}, {15'd0, done}, 16'd0);
    @(posedge clk); @(negedge clk);
    check({req, " R2 done high c+2"}, {15'd0, done}, 16'd1);
    check({req, " R3 aWe/dWe"}, {14'd0, aWe, dWe}, 16'd3);
    check({req, " R3 tWe"}, {15'd0, tWe}, {15'd0, f48});
    check({req, " R5 D cleared"}, dReg, 16'h0000);
    check({req, " R6 mantissa"}, aReg, expv[15:0]);
    if (f48) check({req, " R7 T word"}, tReg, expv[31:16]);
    else     check({req, " R4 T held"}, tReg, tBefore);
    @(posedge clk); @(negedge clk);
    check({req, " R2 done low c+3"}, {15'd0, done}, 16'd0);
  endtask

  task automatic testReset();
    check("R2 reset done", {15'd0, done}, 16'd0);
    check("R3 reset we", {13'd0, tWe, aWe, dWe}, 16'd0);
    check("reset T", tReg, 16'h0000);
    check("reset A", aReg, 16'h0000);
  endtask

  task automatic testIdentity();
    runOp("R8 one", 16'hD310, 16'd1, 1'b1);
    check("R8 T one", tReg, 16'h4001);
    check("R8 A one", aReg, 16'h8000);
    runOp("R8 hundred", 16'hD310, 16'd100, 1'b1);
    runOp("R7 negative", 16'hD310, 16'hFFFB, 1'b1);
    check("R7 sign bit", {15'd0, tReg[15]}, 16'd1);
  endtask

  task automatic testDoubling();
    logic [15:0] t16, a16;
    runOp("R9 base", 16'hD310, 16'd3, 1'b1);
    t16 = tReg; a16 = aReg;
    runOp("R9 step", 16'hD311, 16'd3, 1'b1);
    check("R9 exponent+1", tReg, t16 + 16'd1);
    check("R9 mantissa same", aReg, a16);
  endtask

  task automatic testMinInt();
    runOp("R10 min", 16'hD310, 16'h8000, 1'b1);
    check("R10 T", tReg, 16'hC010);
    check("R10 A", aReg, 16'h8000);
  endtask

  task automatic testZero();
    runOp("R11 zero", 16'hD332, 16'd0, 1'b1);
    check("R11 T zero", tReg, 16'h0000);
    check("R11 A zero", aReg, 16'h0000);
  endtask

  task automatic testFmt32();
    runOp("R4 prime", 16'hD310, 16'd7, 1'b1);
    runOp("R4 32bit", 16'hD305, 16'hFF00, 1'b0);
    check("R4 T unchanged", tReg, model(16'hD310, 16'd7) >> 16);
  endtask

  task automatic testScaleRange();
    runOp("R12 min scale", 16'hD380, 16'h7FFF, 1'b1);
    check("R12 T min", tReg, 16'h3F7F);
    check("R12 A min", aReg, 16'hFFFE);
    runOp("R12 max scale", 16'hD37F, 16'd1, 1'b1);
    check("R12 T max", tReg, 16'h4070);
  endtask

  task automatic testOtherOpcode();
    logic [15:0] t0, a0;
    logic seen;
    t0 = tReg; a0 = aReg; seen = 1'b0;
    instr = 16'hD410; operand = 16'd9; fmt48 = 1'b1; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (done || tWe || aWe || dWe) seen = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    check("R1 no done/we", {15'd0, seen}, 16'd0);
    check("R1 T unchanged", tReg, t0);
    check("R1 A unchanged", aReg, a0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIdentity();
    testDoubling();
    testMinInt();
    testZero();
    testFmt32();
    testScaleRange();
    testOtherOpcode();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule